// File: doc/BRIEF.md
# Dual-Channel Byte-Loaded Converter Register Front End

This block is the clocked digital front end of a two-channel, 12-bit, double-buffered converter that is fed from an 8-bit bus. Each channel has a staging register and a code register. The staging register is written one byte at a time. The code register drives that channel's 12-bit output code.

A 12-bit word arrives as two writes, in either order. A low-byte write fills bits 7..0. A high-byte write fills bits 11..8 from bus bits 3..0. A load strobe copies both staging registers into both code registers at once.

If the load strobe is held low during writes, the code register follows its staging register. Each write then reaches the output directly, which is the automatic mode. A clear input zeroes every register. All bus and strobe inputs are sampled on the system clock through a two-stage synchronizer.

The bus is a plain strobe interface. There is no valid/ready handshake and no back-pressure: every sampled write is accepted, in the cycle it is sampled.

Top module: `dual_byte_dac_regs`

## Requirements
- R1: A sampled write with `wr_n`=0 and `byte_hi`=0 loads `bus_data[7:0]` into bits 7..0 of the selected channel's staging register.
- R2: A sampled write with `wr_n`=0 and `byte_hi`=1 loads `bus_data[3:0]` into bits 11..8 of the selected channel's staging register. Bus bits 7..4 are ignored. Bits 7..0 of that register do not change.
- R3: The two bytes of a word may be written in either order, and the assembled word is the same.
- R4: `chan_b`=0 selects channel A and `chan_b`=1 selects channel B. The channel that is not selected is unaffected by the write.
- R5: While `wr_n`=1, both staging registers hold their contents, whatever `bus_data`, `byte_hi` or `chan_b` do.
- R6: A sampled rising edge of `load_n` (previous sample 0, current sample 1) copies both staging registers into both code registers in the same cycle.
- R7: While the sampled `wr_n` and `load_n` are both 0, each code register takes its staging register's new value in the same cycle. The second byte of a word therefore reaches the output together with its write, and two words take four write cycles.
- R8: In every other case the code registers hold. This covers `load_n` held high, and `load_n` held low while `wr_n`=1. Strobed mode therefore takes four writes and one load pulse.
- R9: While the sampled `clear_n`=0, all four registers are zero. Clear has priority over a write. After `clear_n` returns high with `wr_n`=1, the registers stay zero.
- R10: An input change applied before clock edge n is visible on `code_a`/`code_b` after edge n+2: two synchronizer edges plus one register edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| bus_data | input | 8 | Byte bus |
| wr_n | input | 1 | Write strobe, active low |
| byte_hi | input | 1 | 0 selects the low byte, 1 selects the high nibble |
| chan_b | input | 1 | 0 selects channel A, 1 selects channel B |
| load_n | input | 1 | Load strobe; a rising edge transfers both channels |
| clear_n | input | 1 | Zeroes all registers, active low |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |

## Verification
Every result of this block is due exactly three rising edges after the inputs that cause it are driven. This holds for a byte write seen through transparency, a load edge and a clear alike.

The bench drives inputs on falling edges. For each driven cycle it pushes the codes its own register model predicts. The monitor compares the outputs half a cycle after the third following rising edge against the entry pushed three driven cycles earlier. This keeps every comparison aligned to the synchronizer and register latency.

Hold and ignore cases (R2, R5, R8) are exposed by a later load or transparent cycle that brings the staging contents to the outputs.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  parameter int BUS_W  = 8;
  parameter int WORD_W = 12;
  localparam int HI_W  = WORD_W - BUS_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic             clr_n;
    logic             wr_n;
    logic             ld_n;
    logic             hi;
    logic             chb;
    logic [BUS_W-1:0] data;
  } bus_sample_t;

  localparam int SAMPLE_W = $bits(bus_sample_t);
endpackage

// File: rtl/dbd_sync.sv
module dbd_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[g] <= IDLE;
          else        stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dbd_chan.sv
module dbd_chan
  import dbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             wr_en,
  input  logic             hi,
  input  logic [BUS_W-1:0] data,
  input  logic             follow,
  input  logic             xfer,
  output word_t            stage_q,
  output word_t            code_q
);
  word_t stage_nxt;

  always_comb begin
    stage_nxt = stage_q;
    if (wr_en) begin
      if (hi) stage_nxt[WORD_W-1:BUS_W] = data[HI_W-1:0];
      else    stage_nxt[BUS_W-1:0]      = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code_q  <= '0;
    end else if (!clr_n) begin
      stage_q <= '0;
      code_q  <= '0;
    end else begin
      stage_q <= stage_nxt;
      if (follow)    code_q <= stage_nxt;
      else if (xfer) code_q <= stage_q;
    end
  end

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (stage_q == '0 && code_q == '0));
  // R5
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !wr_en) |=> $stable(stage_q));
  // R2
  nibble_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && wr_en && hi) |=> stage_q[BUS_W-1:0] == $past(stage_q[BUS_W-1:0]));
  // R7
  follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && follow) |=> code_q == stage_q);
  // R6
  xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && xfer && !follow) |=> code_q == $past(stage_q));
  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !follow && !xfer) |=> $stable(code_q));
endmodule

// File: rtl/dual_byte_dac_regs.sv
module dual_byte_dac_regs
  import dbd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             wr_n,
  input  logic             byte_hi,
  input  logic             chan_b,
  input  logic             load_n,
  input  logic             clear_n,
  output logic [WORD_W-1:0] code_a,
  output logic [WORD_W-1:0] code_b
);
  localparam int N_CH = 2;
  localparam bus_sample_t IDLE_SAMPLE = '{clr_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1,
                                          hi: 1'b0, chb: 1'b0, data: '0};

  bus_sample_t raw, smp;
  logic        ld_prev;
  logic        xfer, follow;
  word_t       stage_w [N_CH];
  word_t       code_w  [N_CH];

  assign raw = '{clr_n: clear_n, wr_n: wr_n, ld_n: load_n,
                 hi: byte_hi, chb: chan_b, data: bus_data};

  dbd_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES), .IDLE(IDLE_SAMPLE)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (smp)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ld_prev <= 1'b1;
    else        ld_prev <= smp.ld_n;

  assign xfer   = smp.ld_n & ~ld_prev;
  assign follow = ~smp.wr_n & ~smp.ld_n;

  genvar c;
  generate
    for (c = 0; c < N_CH; c++) begin : g_ch
      logic sel;
      assign sel = (smp.chb == c[0]);
      dbd_chan i_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (smp.clr_n),
        .wr_en   (~smp.wr_n & sel),
        .hi      (smp.hi),
        .data    (smp.data),
        .follow  (follow),
        .xfer    (xfer),
        .stage_q (stage_w[c]),
        .code_q  (code_w[c])
      );
    end
  endgenerate

  assign code_a = code_w[0];
  assign code_b = code_w[1];

  // R4
  chan_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp.clr_n && !smp.wr_n && smp.chb) |=> $stable(stage_w[0]));
endmodule

// File: tb/test_dual_byte_dac_regs.sv
`timescale 1ns/100ps
module test_dual_byte_dac_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       wr_n = 1'b1, byte_hi = 1'b0, chan_b = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic [11:0] code_a, code_b;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic [11:0] a;
    logic [11:0] b;
    string       req;
  } exp_t;
  exp_t sb[$];

  // bench register model
  logic [11:0] m_sa = '0, m_sb = '0, m_ca = '0, m_cb = '0;
  logic        m_ldp = 1'b1;

  always #2.5 clk = ~clk;

  dual_byte_dac_regs i_dual_byte_dac_regs (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .wr_n(wr_n),
    .byte_hi(byte_hi), .chan_b(chan_b), .load_n(load_n), .clear_n(clear_n),
    .code_a(code_a), .code_b(code_b)
  );

  task automatic drive(input logic w, input logic l, input logic h,
                       input logic cb, input logic [7:0] d, input logic cl,
                       input string req);
    logic [11:0] na, nb;
    @(negedge clk);
    wr_n = w; load_n = l; byte_hi = h; chan_b = cb; bus_data = d; clear_n = cl;
    if (!cl) begin
      m_sa = '0; m_sb = '0; m_ca = '0; m_cb = '0;
    end else begin
      na = m_sa; nb = m_sb;
      if (!w) begin
        if (!cb) begin if (h) na[11:8] = d[3:0]; else na[7:0] = d; end
        else     begin if (h) nb[11:8] = d[3:0]; else nb[7:0] = d; end
      end
      if (!w && !l) begin m_ca = na; m_cb = nb; end
      else if (l && !m_ldp) begin m_ca = m_sa; m_cb = m_sb; end
      m_sa = na; m_sb = nb;
    end
    m_ldp = l;
    sb.push_back('{a: m_ca, b: m_cb, req: req});
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1, load_n, 0, 0, 8'h00, 1, req);
  endtask

  // monitor: result of a driven cycle is due three rising edges later (R10)
  always @(negedge clk) begin
    #1;
    if (sb.size() == 4) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (code_a !== e.a || code_b !== e.b) begin
        fails++;
        $display("FAIL %s/R10: code_a=%h code_b=%h expected a=%h b=%h",
                 e.req, code_a, code_b, e.a, e.b);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (code_a !== 12'h000 || code_b !== 12'h000) begin
      fails++;
      $display("FAIL R9 reset: a=%h b=%h expected 000 000", code_a, code_b);
    end

    // strobed mode: A low then high, B high then low
    drive(0, 1, 0, 0, 8'h34, 1, "R1");
    drive(1, 1, 0, 0, 8'h00, 1, "R8");
    drive(0, 1, 1, 0, 8'hF2, 1, "R2");
    drive(0, 1, 1, 1, 8'h0A, 1, "R3");
    drive(0, 1, 0, 1, 8'hBC, 1, "R3");
    idle(2, "R8");
    drive(1, 0, 0, 0, 8'h00, 1, "R8");
    drive(1, 1, 0, 0, 8'h00, 1, "R6");
    idle(2, "R6");

    // write strobe high: bus activity ignored
    drive(1, 1, 0, 0, 8'hFF, 1, "R5");
    drive(1, 1, 1, 1, 8'hEE, 1, "R5");
    drive(1, 0, 0, 0, 8'h00, 1, "R5");
    drive(1, 1, 0, 0, 8'h00, 1, "R5");
    idle(2, "R5");

    // automatic mode: load held low
    drive(1, 0, 0, 0, 8'h00, 1, "R8");
    drive(0, 0, 0, 0, 8'h55, 1, "R7");
    drive(0, 0, 1, 0, 8'h07, 1, "R7");
    drive(0, 0, 1, 1, 8'h09, 1, "R4");
    drive(0, 0, 0, 1, 8'h66, 1, "R4");
    drive(1, 0, 0, 0, 8'h00, 1, "R8");
    drive(0, 0, 1, 0, 8'h03, 1, "R2");
    drive(0, 0, 1, 1, 8'hF1, 1, "R2");
    idle(2, "R7");
    drive(1, 1, 0, 0, 8'h00, 1, "R6");
    idle(2, "R8");

    // clear with a write in progress, release with write high
    drive(0, 1, 0, 0, 8'hAA, 0, "R9");
    drive(0, 0, 1, 1, 8'h0F, 0, "R9");
    drive(1, 1, 0, 0, 8'h00, 1, "R9");
    drive(1, 0, 0, 0, 8'h00, 1, "R9");
    drive(1, 1, 0, 0, 8'h00, 1, "R9");
    idle(2, "R9");

    // reversed order on A after clear, then strobed load
    drive(0, 1, 1, 0, 8'h0C, 1, "R3");
    drive(0, 1, 0, 0, 8'h21, 1, "R3");
    drive(1, 0, 0, 0, 8'h00, 1, "R6");
    drive(1, 1, 0, 0, 8'h00, 1, "R6");
    idle(5, "R6");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected <= 5000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule